// File: doc/BRIEF.md
# Line-Write SDRAM Sequencer with Data-Bus Handoff

This block lets an external pixel streamer write an image straight into SDRAM, one memory row per image line. The sequencer always drives the command pins (clock enable, row strobe, column strobe, write enable and the eleven address pins). An owner-select output gives the memory data bus and clock to the streamer only while a full-page write burst is open. A host controls the block with three single-cycle requests: open a frame at a start address, advance to a new line, and close the frame.

While it is parked, the memory is held in self-refresh. An open request brings the memory out of self-refresh, activates the row taken from the start address and starts a write burst at column 0. Only then does it hand the bus over. A next-line request takes the bus back and ends the running burst. It then precharges all banks, activates the given line number as the new row, starts a new burst and hands the bus back. A close request takes the bus back, ends the burst and puts the memory back into self-refresh.

Top module: `line_write_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the outputs are: clock enable low, command NOP, address 0, bus owned by the sequencer (owner select 0), busy low, error low.
- R2: Commands are written on {ras_n,cas_n,we_n} as NOP=111, ACT=011, WR=100, BT (burst terminate)=110, PRE=010, REF=001. An open request accepted while parked produces one command per cycle, starting the next cycle: NOP, NOP, NOP, REF, NOP, ACT, NOP, WR, NOP. Clock enable is high from the first of these cycles on.
- R3: The ACT of an open sequence carries bits [20:10] of the open address on address pins A0..A10.
- R4: A next-line request accepted while streaming produces, from the next cycle: NOP, NOP, BT, PRE, NOP, ACT, NOP, WR, NOP.
- R5: The ACT of a next-line sequence carries the requested line number on A0..A10 without any shift.
- R6: A close request accepted while streaming produces NOP, BT, PRE, NOP, REF, NOP. Clock enable goes low in the REF cycle and stays low while the sequencer is parked.
- R7: Every PRE drives A10 high. Every WR drives all address pins to 0 (column 0, no auto-precharge).
- R8: The owner select changes only in a cycle whose command is NOP. It goes to the streamer (1) in the last cycle of an open or next-line sequence and returns to the sequencer (0) in the first cycle of a next-line or close sequence. While it is 1, the command is NOP.
- R9: A next-line or close request that arrives while parked or while a sequence runs is ignored. It sets the error flag, and only reset clears that flag.
- R10: Busy is high from the cycle that shows the first command of an accepted sequence up to the cycle before its last command. It is low in the handoff cycle and in the self-refresh-return cycle. The owner select is never 1 while busy is high.
- R11: When next-line and close requests arrive in the same streaming cycle, close wins and the next-line request is dropped without an error.
- R12: An open request while streaming or while a sequence runs is ignored and does not set the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer and memory command clock |
| rst | input | 1 | Synchronous active-high reset |
| open_req | input | 1 | Start a frame (one-cycle pulse) |
| open_addr | input | ADDR_W | Byte address of the frame start; bits [20:10] select the row |
| next_req | input | 1 | Advance to a new line (one-cycle pulse) |
| next_line | input | PIN_W | Row number of the new line |
| close_req | input | 1 | Finish the frame and enter self-refresh (one-cycle pulse) |
| mem_cke | output | 1 | Memory clock enable |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | PIN_W | Memory address pins A0..A10 |
| bus_to_ext | output | 1 | Data bus and clock owner: 1 = streamer, 0 = sequencer |
| busy | output | 1 | A command sequence is in progress |
| seq_error | output | 1 | Sticky flag for a misplaced next-line or close request |

## Verification
Several things can fall in the same cycle. A request can arrive on the very edge that emits the last command of a sequence, while the phase has not yet left the running state. Next-line and close can also arrive together while streaming, and a request can coincide with the handoff. The bench provokes each case with directed pulses at those cycles. A behavioural queue model sets the expected outcome for each one: a late request counts as misplaced and only sets the error flag, and a simultaneous close wins over next-line. Every pin is compared with the model on every clock.

// File: rtl/lws_pkg.sv
package lws_pkg;

    localparam int STEP_IDX_W = 4;
    localparam int PRE_BIT    = 10;

    typedef enum logic [2:0] {
        CMD_MRS = 3'b000,
        CMD_REF = 3'b001,
        CMD_PRE = 3'b010,
        CMD_ACT = 3'b011,
        CMD_WR  = 3'b100,
        CMD_RD  = 3'b101,
        CMD_BT  = 3'b110,
        CMD_NOP = 3'b111
    } cmd_e;

    typedef enum logic [1:0] {
        SEQ_OPEN  = 2'd0,
        SEQ_NEXT  = 2'd1,
        SEQ_CLOSE = 2'd2
    } seq_e;

    typedef enum logic [1:0] {
        PH_PARKED = 2'd0,
        PH_RUN    = 2'd1,
        PH_STREAM = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        AD_ZERO = 2'd0,
        AD_ROW  = 2'd1,
        AD_PRE  = 2'd2
    } asrc_e;

    typedef struct packed {
        cmd_e  cmd;
        asrc_e asrc;
        logic  cke;
        logic  ext;
        logic  last;
    } step_t;

    function automatic step_t mk_step(cmd_e c, asrc_e a, logic k, logic e, logic l);
        step_t s;
        s.cmd  = c;
        s.asrc = a;
        s.cke  = k;
        s.ext  = e;
        s.last = l;
        return s;
    endfunction

    function automatic step_t step_lookup(seq_e sq, logic [STEP_IDX_W-1:0] i);
        step_t s;
        s = mk_step(CMD_NOP, AD_ZERO, 1'b0, 1'b0, 1'b1);
        case (sq)
            SEQ_OPEN: begin
                case (i)
                    4'd0, 4'd1, 4'd2, 4'd4, 4'd6:
                            s = mk_step(CMD_NOP, AD_ZERO, 1'b1, 1'b0, 1'b0);
                    4'd3:   s = mk_step(CMD_REF, AD_ZERO, 1'b1, 1'b0, 1'b0);
                    4'd5:   s = mk_step(CMD_ACT, AD_ROW,  1'b1, 1'b0, 1'b0);
                    4'd7:   s = mk_step(CMD_WR,  AD_ZERO, 1'b1, 1'b0, 1'b0);
                    4'd8:   s = mk_step(CMD_NOP, AD_ZERO, 1'b1, 1'b1, 1'b1);
                    default: ;
                endcase
            end
            SEQ_NEXT: begin
                case (i)
                    4'd0, 4'd1, 4'd4, 4'd6:
                            s = mk_step(CMD_NOP, AD_ZERO, 1'b1, 1'b0, 1'b0);
                    4'd2:   s = mk_step(CMD_BT,  AD_ZERO, 1'b1, 1'b0, 1'b0);
                    4'd3:   s = mk_step(CMD_PRE, AD_PRE,  1'b1, 1'b0, 1'b0);
                    4'd5:   s = mk_step(CMD_ACT, AD_ROW,  1'b1, 1'b0, 1'b0);
                    4'd7:   s = mk_step(CMD_WR,  AD_ZERO, 1'b1, 1'b0, 1'b0);
                    4'd8:   s = mk_step(CMD_NOP, AD_ZERO, 1'b1, 1'b1, 1'b1);
                    default: ;
                endcase
            end
            SEQ_CLOSE: begin
                case (i)
                    4'd0, 4'd3:
                            s = mk_step(CMD_NOP, AD_ZERO, 1'b1, 1'b0, 1'b0);
                    4'd1:   s = mk_step(CMD_BT,  AD_ZERO, 1'b1, 1'b0, 1'b0);
                    4'd2:   s = mk_step(CMD_PRE, AD_PRE,  1'b1, 1'b0, 1'b0);
                    4'd4:   s = mk_step(CMD_REF, AD_ZERO, 1'b0, 1'b0, 1'b0);
                    4'd5:   s = mk_step(CMD_NOP, AD_ZERO, 1'b0, 1'b0, 1'b1);
                    default: ;
                endcase
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/lws_step_rom.sv
module lws_step_rom
    import lws_pkg::*;
(
    input  seq_e                  seq_i,
    input  logic [STEP_IDX_W-1:0] idx_i,
    output step_t                 step_o
);

    always_comb begin
        step_o = step_lookup(seq_i, idx_i);
    end

endmodule

// File: rtl/lws_ctrl.sv
module lws_ctrl
    import lws_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PIN_W     = 11,
    parameter int ROW_SHIFT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open_req,
    input  logic [ADDR_W-1:0] open_addr,
    input  logic              next_req,
    input  logic [PIN_W-1:0]  next_line,
    input  logic              close_req,
    output step_t             step_o,
    output logic              emit_o,
    output logic [PIN_W-1:0]  row_o,
    output logic              busy_o,
    output logic              err_o
);

    phase_e                ph_q;
    seq_e                  seq_q, seq_sel;
    logic [STEP_IDX_W-1:0] idx_q, idx_sel;
    logic [PIN_W-1:0]      row_q;
    logic                  err_q;
    logic                  acc_open, acc_next, acc_close, acc_any, misuse;
    logic [PIN_W-1:0]      open_row;

    assign open_row  = PIN_W'(open_addr >> ROW_SHIFT);

    assign acc_open  = (ph_q == PH_PARKED) && open_req;
    assign acc_close = (ph_q == PH_STREAM) && close_req;
    assign acc_next  = (ph_q == PH_STREAM) && next_req && !close_req;
    assign acc_any   = acc_open || acc_close || acc_next;
    assign misuse    = (next_req || close_req) && (ph_q != PH_STREAM);

    always_comb begin
        seq_sel = seq_q;
        idx_sel = idx_q;
        if (acc_open) begin
            seq_sel = SEQ_OPEN;
            idx_sel = '0;
        end else if (acc_close) begin
            seq_sel = SEQ_CLOSE;
            idx_sel = '0;
        end else if (acc_next) begin
            seq_sel = SEQ_NEXT;
            idx_sel = '0;
        end
    end

    lws_step_rom u_rom (
        .seq_i  (seq_sel),
        .idx_i  (idx_sel),
        .step_o (step_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_PARKED;
            seq_q <= SEQ_OPEN;
            idx_q <= '0;
            row_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (misuse) begin
                err_q <= 1'b1;
            end
            if (acc_any) begin
                seq_q <= seq_sel;
                idx_q <= STEP_IDX_W'(1);
                ph_q  <= PH_RUN;
                if (acc_open) begin
                    row_q <= open_row;
                end else if (acc_next) begin
                    row_q <= next_line;
                end
            end else if (ph_q == PH_RUN) begin
                idx_q <= idx_q + 1'b1;
                if (step_o.last) begin
                    ph_q <= (seq_q == SEQ_CLOSE) ? PH_PARKED : PH_STREAM;
                end
            end
        end
    end

    assign emit_o = acc_any || (ph_q == PH_RUN);
    assign row_o  = row_q;
    assign busy_o = (ph_q == PH_RUN);
    assign err_o  = err_q;

    AST_PARK_NO_RUN_ERR: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_PARKED && next_req) |=> err_q);                        // R9
    AST_OPEN_IGNORED_BUSY: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_RUN && open_req && !step_o.last) |=> (ph_q == PH_RUN && idx_q == $past(idx_q) + 1'b1)); // R12

endmodule

// File: rtl/lws_pins.sv
module lws_pins
    import lws_pkg::*;
#(
    parameter int PIN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             emit_i,
    input  step_t            step_i,
    input  logic [PIN_W-1:0] row_i,
    output cmd_e             cmd_o,
    output logic [PIN_W-1:0] addr_o,
    output logic             cke_o,
    output logic             ext_o
);

    localparam logic [PIN_W-1:0] PRE_WORD = PIN_W'(1) << PRE_BIT;

    logic [PIN_W-1:0] addr_sel;

    always_comb begin
        case (step_i.asrc)
            AD_ROW:  addr_sel = row_i;
            AD_PRE:  addr_sel = PRE_WORD;
            default: addr_sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_o  <= CMD_NOP;
            addr_o <= '0;
            cke_o  <= 1'b0;
            ext_o  <= 1'b0;
        end else if (emit_i) begin
            cmd_o  <= step_i.cmd;
            addr_o <= addr_sel;
            cke_o  <= step_i.cke;
            ext_o  <= step_i.ext;
        end else begin
            cmd_o  <= CMD_NOP;
            addr_o <= '0;
        end
    end

    AST_PRE_A10_HIGH: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_PRE) |-> addr_o[PRE_BIT]);                          // R7
    AST_WRITE_COL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cmd_o == CMD_WR) |-> (addr_o == '0));                             // R7
    AST_HANDOFF_ON_NOP: assert property (@(posedge clk) disable iff (rst)
        (ext_o != $past(ext_o)) |-> (cmd_o == CMD_NOP));                   // R8

endmodule

// File: rtl/line_write_seq.sv
module line_write_seq
    import lws_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PIN_W     = 11,
    parameter int ROW_SHIFT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open_req,
    input  logic [ADDR_W-1:0] open_addr,
    input  logic              next_req,
    input  logic [PIN_W-1:0]  next_line,
    input  logic              close_req,
    output logic              mem_cke,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [PIN_W-1:0]  mem_addr,
    output logic              bus_to_ext,
    output logic              busy,
    output logic              seq_error
);

    step_t            step_w;
    logic             emit_w;
    logic [PIN_W-1:0] row_w;
    cmd_e             cmd_w;

    lws_ctrl #(
        .ADDR_W    (ADDR_W),
        .PIN_W     (PIN_W),
        .ROW_SHIFT (ROW_SHIFT)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .open_req  (open_req),
        .open_addr (open_addr),
        .next_req  (next_req),
        .next_line (next_line),
        .close_req (close_req),
        .step_o    (step_w),
        .emit_o    (emit_w),
        .row_o     (row_w),
        .busy_o    (busy),
        .err_o     (seq_error)
    );

    lws_pins #(
        .PIN_W (PIN_W)
    ) u_pins (
        .clk    (clk),
        .rst    (rst),
        .emit_i (emit_w),
        .step_i (step_w),
        .row_i  (row_w),
        .cmd_o  (cmd_w),
        .addr_o (mem_addr),
        .cke_o  (mem_cke),
        .ext_o  (bus_to_ext)
    );

    assign {mem_ras_n, mem_cas_n, mem_we_n} = cmd_w;

    AST_EXT_ONLY_NOP: assert property (@(posedge clk) disable iff (rst)
        bus_to_ext |-> (cmd_w == CMD_NOP));                                // R8
    AST_ERROR_STICKY: assert property (@(posedge clk) disable iff (rst)
        seq_error |=> seq_error);                                          // R9
    AST_BUSY_KEEPS_BUS: assert property (@(posedge clk) disable iff (rst)
        busy |-> !bus_to_ext);                                             // R10
    AST_PARKED_CKE_LOW: assert property (@(posedge clk) disable iff (rst)
        (!busy && !bus_to_ext && !$past(busy)) |-> !mem_cke);              // R6

endmodule

// File: tb/line_write_seq_tb.sv
module line_write_seq_tb_top;

    localparam int ADDR_W = 32;
    localparam int PIN_W  = 11;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              open_req = 1'b0;
    logic [ADDR_W-1:0] open_addr = '0;
    logic              next_req = 1'b0;
    logic [PIN_W-1:0]  next_line = '0;
    logic              close_req = 1'b0;
    logic              mem_cke, mem_ras_n, mem_cas_n, mem_we_n;
    logic [PIN_W-1:0]  mem_addr;
    logic              bus_to_ext, busy, seq_error;

    always #2 clk = ~clk;

    line_write_seq #(.ADDR_W(ADDR_W), .PIN_W(PIN_W), .ROW_SHIFT(10)) dut_i (
        .clk(clk), .rst(rst),
        .open_req(open_req), .open_addr(open_addr),
        .next_req(next_req), .next_line(next_line), .close_req(close_req),
        .mem_cke(mem_cke), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr),
        .bus_to_ext(bus_to_ext), .busy(busy), .seq_error(seq_error)
    );

    typedef struct {
        bit [2:0]  c;
        bit [10:0] a;
        bit        k;
        bit        x;
        int        tag;
    } word_t;

    word_t     q[$];
    int        m_mode = 0;
    int        m_tgt  = 0;
    bit [2:0]  e_cmd  = 3'b111;
    bit [10:0] e_a    = '0;
    bit        e_cke  = 1'b0;
    bit        e_ext  = 1'b0;
    bit        e_busy = 1'b0;
    bit        e_err  = 1'b0;
    int        e_tag  = 1;
    bit        armed  = 1'b0;
    int        errors = 0;
    int        checks = 0;

    function automatic string tag_name(int t);
        case (t)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10"; 11: return "R11"; 12: return "R12";
            default: return "R?";
        endcase
    endfunction

    task automatic push(bit [2:0] c, bit [10:0] a, bit k, bit x, int t);
        word_t w;
        w.c = c; w.a = a; w.k = k; w.x = x; w.tag = t;
        q.push_back(w);
    endtask

    // R2 / R3 open list
    task automatic load_open(bit [10:0] row);
        push(3'b111, 0, 1, 0, 2); push(3'b111, 0, 1, 0, 2); push(3'b111, 0, 1, 0, 2);
        push(3'b001, 0, 1, 0, 2); push(3'b111, 0, 1, 0, 2);
        push(3'b011, row, 1, 0, 3); push(3'b111, 0, 1, 0, 2);
        push(3'b100, 0, 1, 0, 7); push(3'b111, 0, 1, 1, 8);
    endtask

    // R4 / R5 next-line list
    task automatic load_next(bit [10:0] line);
        push(3'b111, 0, 1, 0, 8); push(3'b111, 0, 1, 0, 4); push(3'b110, 0, 1, 0, 4);
        push(3'b010, 11'h400, 1, 0, 7); push(3'b111, 0, 1, 0, 4);
        push(3'b011, line, 1, 0, 5); push(3'b111, 0, 1, 0, 4);
        push(3'b100, 0, 1, 0, 7); push(3'b111, 0, 1, 1, 8);
    endtask

    // R6 close list (tag 11 when it won over a simultaneous next-line)
    task automatic load_close(int t);
        push(3'b111, 0, 1, 0, 8); push(3'b110, 0, 1, 0, t);
        push(3'b010, 11'h400, 1, 0, 7); push(3'b111, 0, 1, 0, t);
        push(3'b001, 0, 0, 0, t); push(3'b111, 0, 0, 0, t);
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        word_t w;
        armed = 1'b1;
        if (rst) begin
            q.delete();
            m_mode = 0; e_cmd = 3'b111; e_a = 0; e_cke = 0; e_ext = 0;
            e_busy = 0; e_err = 0; e_tag = 1;
        end else begin
            if ((next_req || close_req) && m_mode != 2) e_err = 1'b1;
            if (m_mode == 0 && open_req) begin
                load_open(11'((open_addr >> 10) & 32'h7FF));
                m_tgt = 2; m_mode = 1;
            end else if (m_mode == 2 && close_req) begin
                load_close(next_req ? 11 : 6);
                m_tgt = 0; m_mode = 1;
            end else if (m_mode == 2 && next_req) begin
                load_next(next_line);
                m_tgt = 2; m_mode = 1;
            end
            if (m_mode == 1) begin
                w = q.pop_front();
                e_cmd = w.c; e_a = w.a; e_cke = w.k; e_ext = w.x; e_tag = w.tag;
                if (q.size() == 0) m_mode = m_tgt;
            end else begin
                e_cmd = 3'b111; e_a = 0;
                e_cke = (m_mode == 2); e_ext = (m_mode == 2);
                e_tag = (m_mode == 2) ? (open_req ? 12 : 8) : 1;
            end
            e_busy = (m_mode == 1);
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (armed) begin
            chk({mem_ras_n, mem_cas_n, mem_we_n} == e_cmd, tag_name(e_tag), "cmd",
                {mem_ras_n, mem_cas_n, mem_we_n}, e_cmd);
            chk(mem_addr == e_a, tag_name(e_tag), "addr", mem_addr, e_a);
            chk(mem_cke == e_cke, tag_name(e_tag), "cke", mem_cke, e_cke);
            chk(bus_to_ext == e_ext, tag_name(e_tag == 1 ? 1 : 8), "owner", bus_to_ext, e_ext);
            chk(busy == e_busy, tag_name(e_tag == 1 ? 1 : 10), "busy", busy, e_busy);
            chk(seq_error == e_err, tag_name(e_tag == 1 ? 1 : 9), "error", seq_error, e_err);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(bit o, bit nx, bit cl);
        open_req = o; next_req = nx; close_req = cl;
        @(negedge clk);
        open_req = 0; next_req = 0; close_req = 0;
    endtask

    initial begin
        tick(3);
        rst = 0;
        tick(3);                                      // R1 idle state
        open_addr = 32'h0015_5C00;                    // R3 row 0x557
        pulse(1, 0, 0);
        tick(12);                                     // R2 then streaming R8
        next_line = 11'h2AB;                          // R5 unshifted line
        pulse(0, 1, 0);
        tick(8);
        pulse(1, 0, 0);                               // R12 open while streaming
        tick(3);
        pulse(0, 1, 1);                               // R11 close wins over next
        tick(10);
        pulse(0, 0, 1);                               // R9 close while parked
        tick(2);
        open_addr = 32'hFFFF_FC00;                    // R3 row 0x7FF
        pulse(1, 0, 0);
        tick(3);
        pulse(0, 1, 0);                               // R9 next during a sequence
        tick(3);
        pulse(1, 0, 0);                               // R12 open during a sequence
        tick(1);                                      // R10 edge of last step next
        pulse(0, 1, 0);
        tick(4);
        next_line = 11'h000;
        pulse(0, 1, 0);                               // R4 sequence
        tick(12);
        pulse(0, 0, 1);                               // R6 return to self-refresh
        tick(10);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule